// File: doc/BRIEF.md
# Partially Guarded Signed Array Multiplier

This block multiplies two signed operands of width `W` and returns the full signed product of width `2*W`. Its partial-product array is divided by columns. The low region covers the lower `L = 2*W - NM` product columns. The high region covers the upper `NM` columns. Each operand has its own bound on the count of redundant sign bits. A redundant sign bit is a bit below the MSB that equals the MSB. When an operand pair is loaded and both operands reach their bounds, the high region is isolated. Its operand copies are not reloaded, and the carry from the low region into it is forced to zero. The upper `NM` product bits are then taken by sign extension of bit `L-1` of the low region.

The bounds are given as up to three pairs `(B1[p], B2[p])`. Every pair has the same total `NM`. The high region is isolated if any one of the first `NP` pairs is met. The operands are captured on a clock edge where the load strobe is high. The product and the status output are built only from registered state. The result of a load is therefore visible from the cycle after the load and stays until the next load.

Top module: `pgm_mult`

## Requirements
- R1: After a rising edge with `load_i` high, `prod_o` equals the two's-complement product of the `a_i` and `b_i` sampled at that edge, on all `2*W` bits.
- R2: While `load_i` is low, `prod_o` and `hi_off_o` keep their values, whatever `a_i` and `b_i` do.
- R3: While reset is active, and after it until the first load, `prod_o` is zero and `hi_off_o` is low.
- R4: After a load, `hi_off_o` is high exactly when some pair `p < NP` has both conditions true: the top `B1[p]+1` bits of `a_i` are all equal, and the top `B2[p]+1` bits of `b_i` are all equal. With the default single pair `(3,3)` and `W=8`, an operand qualifies exactly when it lies in -16..15.
- R5: When `hi_off_o` is high, bits `2*W-1` down to `L-1` of `prod_o` are all equal, and the product is still exact.
- R6: While `hi_off_o` is high, the high region's operand copies do not change. A guarded load that follows any earlier load still gives the exact product, whatever the earlier operands were.
- R7: A pair with index `NP` or above has no effect on `hi_off_o`. With `NP=3` and pairs `(3,3)`, `(2,4)` and `(4,2)`, the operands `a=16, b=7` are guarded by the second pair alone.
- R8: The most negative operand value has no redundant sign bits. A load where `a_i` is the most negative value never sets `hi_off_o`, as long as every bound is at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| load_i | input | 1 | Capture strobe for the operands |
| a_i | input | W | First signed operand |
| b_i | input | W | Second signed operand |
| prod_o | output | 2*W | Signed product of the last captured pair |
| hi_off_o | output | 1 | High region isolated for the current product |

## Verification
The assertions check four things on every cycle. They compare each loaded product with a reference multiplication (R1). They check that nothing changes without a load (R2). They check that the high-region operand copies stay frozen while isolated (R6). They check the guard decision at its two fixed extremes: zero operands are guarded (R4) and the most negative operand is not (R8). The bench scenarios are needed for the rest. They show the exact guard threshold on each side of a bound, alternative pairs guarding on their own (R7), and reset values (R3). They also show that a guarded product stays exact after the high region has kept stale operands from an earlier large load (R5, R6).

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  localparam int PGM_MAX_PAIRS = 3;
  localparam int PGM_VEC_MAX   = 64;

  // True when the k bits directly below the MSB of a w-bit value all equal the MSB.
  function automatic logic sign_run_ge(input logic [PGM_VEC_MAX-1:0] v,
                                       input int w, input int k);
    logic ok;
    ok = 1'b1;
    for (int i = 1; i < PGM_VEC_MAX; i++) begin
      if (i <= k && i < w) begin
        if (v[6'(w - 1 - i)] != v[6'(w - 1)]) ok = 1'b0;
      end
    end
    return ok;
  endfunction

endpackage

// File: rtl/pgm_rst_sync.sv
module pgm_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/pgm_guard_detect.sv
module pgm_guard_detect
  import pgm_pkg::*;
#(
  parameter int W = 8,
  parameter int NP = 1,
  parameter int B1 [PGM_MAX_PAIRS] = '{3, 3, 3},
  parameter int B2 [PGM_MAX_PAIRS] = '{3, 3, 3}
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         hit_o
);
  logic [NP-1:0] pair_hit;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    always_comb begin
      pair_hit[p] = sign_run_ge(PGM_VEC_MAX'(a_i), W, B1[p]) &
                    sign_run_ge(PGM_VEC_MAX'(b_i), W, B2[p]);
    end
  end

  assign hit_o = |pair_hit;
endmodule

// File: rtl/pgm_pp_row.sv
module pgm_pp_row #(
  parameter int W = 8,
  parameter int I = 0,
  localparam int P = 2 * W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [P-1:0] row_o
);
  // The sign row and the sign column use inverted (NAND) cells so that the signed
  // product comes out right modulo 2^P.
  always_comb begin
    row_o = '0;
    for (int j = 0; j < W; j++) begin
      if ((I == W - 1) != (j == W - 1)) row_o[I + j] = ~(a_i[j] & b_i[I]);
      else                              row_o[I + j] =   a_i[j] & b_i[I];
    end
  end
endmodule

// File: rtl/pgm_region_sum.sv
module pgm_region_sum #(
  parameter int W  = 8,
  parameter int LO = 0,
  parameter int HI = 16,
  localparam int P = 2 * W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [P-1:0] cin_i,
  output logic [P-1:0] sum_o
);
  localparam logic [P-1:0] ONE   = P'(1);
  localparam logic [P-1:0] MASK  = ((HI >= P) ? {P{1'b1}} : ((ONE << HI) - ONE)) &
                                   ~((ONE << LO) - ONE);
  localparam logic [P-1:0] CONST = (ONE << W) | (ONE << (P - 1));

  logic [P-1:0] rows [W];

  for (genvar i = 0; i < W; i++) begin : g_row
    pgm_pp_row #(.W(W), .I(i)) u_row (
      .a_i  (a_i),
      .b_i  (b_i),
      .row_o(rows[i])
    );
  end

  always_comb begin
    sum_o = (CONST & MASK) + cin_i;
    for (int i = 0; i < W; i++) begin
      sum_o = sum_o + (rows[i] & MASK);
    end
  end
endmodule

// File: rtl/pgm_mult.sv
module pgm_mult
  import pgm_pkg::*;
#(
  parameter int W  = 8,
  parameter int NP = 1,
  parameter int B1 [PGM_MAX_PAIRS] = '{3, 2, 4},
  parameter int B2 [PGM_MAX_PAIRS] = '{3, 4, 2}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic [2*W-1:0]   prod_o,
  output logic             hi_off_o
);
  localparam int P  = 2 * W;
  localparam int NM = B1[0] + B2[0];
  localparam int L  = P - NM;

  logic         rst_s;
  logic         guard_d;
  logic [W-1:0] op_a_q, op_a_d, op_b_q, op_b_d;
  logic [W-1:0] hi_a_q, hi_a_d, hi_b_q, hi_b_d;
  logic         sel_q, sel_d;
  logic [P-1:0] lo_sum, hi_sum, carry_g, full;

  pgm_rst_sync u_rst (
    .clk   (clk),
    .rst_ni(rst_n),
    .rst_no(rst_s)
  );

  // The guard decision is taken from the operand ports, so it is known before the
  // edge that would load the high region.
  pgm_guard_detect #(.W(W), .NP(NP), .B1(B1), .B2(B2)) u_det (
    .a_i  (a_i),
    .b_i  (b_i),
    .hit_o(guard_d)
  );

  always_comb begin
    op_a_d = load_i ? a_i : op_a_q;
    op_b_d = load_i ? b_i : op_b_q;
    sel_d  = load_i ? guard_d : sel_q;
    hi_a_d = (load_i && !guard_d) ? a_i : hi_a_q;
    hi_b_d = (load_i && !guard_d) ? b_i : hi_b_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      op_a_q <= '0;
      op_b_q <= '0;
      hi_a_q <= '0;
      hi_b_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      op_a_q <= op_a_d;
      op_b_q <= op_b_d;
      hi_a_q <= hi_a_d;
      hi_b_q <= hi_b_d;
      sel_q  <= sel_d;
    end
  end

  pgm_region_sum #(.W(W), .LO(0), .HI(L)) u_lo (
    .a_i  (op_a_q),
    .b_i  (op_b_q),
    .cin_i('0),
    .sum_o(lo_sum)
  );

  // Carry into the high region is isolated while it is guarded.
  assign carry_g = sel_q ? '0 : {lo_sum[P-1:L], {L{1'b0}}};

  pgm_region_sum #(.W(W), .LO(L), .HI(P)) u_hi (
    .a_i  (hi_a_q),
    .b_i  (hi_b_q),
    .cin_i(carry_g),
    .sum_o(hi_sum)
  );

  assign full = hi_sum + P'(lo_sum[L-1:0]);

  for (genvar k = 0; k < P; k++) begin : g_sx
    if (k < L) begin : g_low
      assign prod_o[k] = full[k];
    end else begin : g_high
      assign prod_o[k] = sel_q ? lo_sum[L-1] : full[k];
    end
  end

  assign hi_off_o = sel_q;
endmodule

// File: rtl/pgm_mult_chk.sv
module pgm_mult_chk #(
  parameter int W = 8,
  localparam int P = 2 * W
) (
  input logic         clk,
  input logic         rst_s,
  input logic         load_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [P-1:0] prod_o,
  input logic         hi_off_o,
  input logic [W-1:0] hi_a,
  input logic [W-1:0] hi_b
);
  logic [P-1:0] ext_a, ext_b, ref_prod;
  assign ext_a    = {{W{a_i[W-1]}}, a_i};
  assign ext_b    = {{W{b_i[W-1]}}, b_i};
  assign ref_prod = ext_a * ext_b;

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  p_prod_r1: assert property (@(posedge clk) disable iff (!rst_s)
    load_i |=> prod_o == $past(ref_prod));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_s)
    !load_i |=> $stable(prod_o) && $stable(hi_off_o));

  p_zero_guard_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (load_i && a_i == '0 && b_i == '0) |=> hi_off_o);

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_s)
    hi_off_o |-> $stable(hi_a) && $stable(hi_b));

  p_most_neg_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (load_i && a_i == MOST_NEG) |=> !hi_off_o);
endmodule

bind pgm_mult pgm_mult_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_s   (rst_s),
  .load_i  (load_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .prod_o  (prod_o),
  .hi_off_o(hi_off_o),
  .hi_a    (hi_a_q),
  .hi_b    (hi_b_q)
);

// File: tb/pgm_mult_tb.sv
module pgm_mult_tb;
  localparam int W = 8;
  localparam int P = 2 * W;
  localparam int BA [3] = '{3, 2, 4};
  localparam int BB [3] = '{3, 4, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [P-1:0] prod1, prod3;
  logic off1, off3;

  int n_chk = 0, n_bad = 0, n_guarded = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pgm_mult #(.W(W), .NP(1), .B1(BA), .B2(BB)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load), .a_i(a), .b_i(b),
    .prod_o(prod1), .hi_off_o(off1));

  pgm_mult #(.W(W), .NP(3), .B1(BA), .B2(BB)) u_dut3 (
    .clk(clk), .rst_n(rst_n), .load_i(load), .a_i(a), .b_i(b),
    .prod_o(prod3), .hi_off_o(off3));

  function automatic int sext_len(logic [W-1:0] v);
    int n = 0;
    for (int k = W - 2; k >= 0; k--) begin
      if (v[k] != v[W-1]) break;
      n++;
    end
    return n;
  endfunction

  function automatic bit exp_guard(logic [W-1:0] x, logic [W-1:0] y, int np);
    bit g = 0;
    for (int p = 0; p < np; p++)
      if (sext_len(x) >= BA[p] && sext_len(y) >= BB[p]) g = 1;
    return g;
  endfunction

  function automatic logic [P-1:0] exp_prod(logic [W-1:0] x, logic [W-1:0] y);
    int xi = int'($signed(x));
    int yi = int'($signed(y));
    int r  = xi * yi;
    return r[P-1:0];
  endfunction

  task automatic chk(string req, logic [P-1:0] act, logic [P-1:0] ex);
    n_chk++;
    if (act !== ex) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, ex);
    end
  endtask

  task automatic load_pair(logic [W-1:0] x, logic [W-1:0] y);
    @(negedge clk);
    a = x; b = y; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // Load, then check product and guard on both instances.
  task automatic run_op(string req, logic [W-1:0] x, logic [W-1:0] y);
    load_pair(x, y);
    chk({req, " R1 prod"}, prod1, exp_prod(x, y));
    chk({req, " R4 guard"}, P'(off1), P'(exp_guard(x, y, 1)));
    chk({req, " R7 prod3"}, prod3, exp_prod(x, y));
    chk({req, " R7 guard3"}, P'(off3), P'(exp_guard(x, y, 3)));
    if (off1) begin
      chk({req, " R5 upper sign"}, P'(prod1[P-1:P-7] == {7{prod1[P-7]}}), P'(1));
      n_guarded++;
    end
  endtask

  task automatic t_reset;
    chk("R3 reset prod", prod1, '0);
    chk("R3 reset off", P'(off1), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 post-reset prod", prod1, '0);
    chk("R3 post-reset off", P'(off3), '0);
  endtask

  task automatic t_small;
    run_op("small", 8'd5, 8'd7);
    run_op("zero", 8'd0, 8'd0);
    run_op("neg small", 8'hF3, 8'hF0);
    run_op("mixed small", 8'd15, 8'hF0);
  endtask

  task automatic t_boundary;
    run_op("R4 edge in", 8'd15, 8'd15);
    chk("R4 15x15 guarded", P'(off1), P'(1));
    run_op("R4 edge out a", 8'd16, 8'd15);
    chk("R4 16x15 not guarded", P'(off1), P'(0));
    run_op("R4 edge in neg", 8'hF0, 8'hF0);
    chk("R4 -16x-16 guarded", P'(off1), P'(1));
    run_op("R4 edge out neg", 8'hEF, 8'd1);
    chk("R4 -17 not guarded", P'(off1), P'(0));
  endtask

  task automatic t_extremes;
    run_op("R8 min*min", 8'h80, 8'h80);
    chk("R8 min not guarded", P'(off3), P'(0));
    run_op("R8 min*0", 8'h80, 8'h00);
    run_op("max*min", 8'h7F, 8'h80);
  endtask

  task automatic t_hold;
    run_op("R2 setup", 8'd9, 8'hFD);
    @(negedge clk);
    a = 8'h55; b = 8'hAA;
    repeat (3) @(negedge clk);
    chk("R2 hold prod", prod1, exp_prod(8'd9, 8'hFD));
    chk("R2 hold off", P'(off1), P'(1));
  endtask

  task automatic t_stale;
    run_op("R6 big", 8'h7B, 8'h91);
    run_op("R6 guarded after big", 8'd3, 8'hFB);
    run_op("R6 guarded again", 8'hF1, 8'd14);
    run_op("R6 big again", 8'h62, 8'h62);
  endtask

  task automatic t_pairs;
    run_op("R7 pair1", 8'd16, 8'd7);
    chk("R7 pair1 dut3 guards", P'(off3), P'(1));
    chk("R7 pair1 dut ignores", P'(off1), P'(0));
    run_op("R7 pair2", 8'd7, 8'd16);
    chk("R7 pair2 dut3 guards", P'(off3), P'(1));
    run_op("R7 none", 8'd16, 8'd16);
    chk("R7 none dut3", P'(off3), P'(0));
  endtask

  task automatic t_sweep;
    logic [31:0] lf = 32'hACE1_1234;
    for (int n = 0; n < 1500; n++) begin
      logic [W-1:0] x, y;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      x = W'($signed(lf[7:0]) >>> lf[10:8]);
      y = W'($signed(lf[18:11]) >>> lf[21:19]);
      run_op("sweep", x, y);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("guarded loads: %0d", n_guarded);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_small();
    t_boundary();
    t_extremes();
    t_hold();
    t_stale();
    t_pairs();
    t_sweep();
    finish_run();
  end
endmodule